// File: doc/BRIEF.md
# UART Channel Control and Flow-Control Unit

This block holds the control word of one UART channel and turns it into three qualifiers for the datapath. `tx_allow_o` tells the transmitter whether it may begin a new character. `rx_allow_o` tells the receiver whether it may accept one. `rts_no` is the active-low request-to-send pin. The serial shifters, FIFOs and baud logic sit outside the block. They report `tx_busy_i` / `rx_busy_i` while a character is on the line, and the receive FIFO reports `rx_fifo_room_i` while it can take one more character.

A qualifier changes only when its section is idle. Enabling or disabling a section during a character therefore takes effect at the next character boundary, and a character is never cut short. Transmit start can be gated by the CTS pin, which passes through a two-flop synchronizer first. The RTS pin either follows receive-FIFO space automatically or comes from a software bit.

Top module: `uart_ctrl_unit`

## Requirements
- R1: After reset the register reads 0x0300 (transmit and receive enables set, global enable clear), `tx_allow_o` and `rx_allow_o` are 0 and `rts_no` is 1.
- R2: A write stores the bits under mask 0xCF87 (bits 15,14,11,10,9,8,7,2,1,0). All other bits, including 31:16, 13:12 and 6:3, read 0. Bit 10 reads back as written.
- R3: While the transmitter is idle, `tx_allow_o` becomes 1 one clock after the register holds global enable (bit 0) and transmit enable (bit 8) both set, and it becomes 0 one clock after either is clear.
- R4: While the receiver is idle, `rx_allow_o` follows global enable (bit 0) AND receive enable (bit 9) with the same one-clock latency.
- R5: While `tx_busy_i` is 1, `tx_allow_o` holds its value, so a transmit disable during a character takes effect only when the character ends.
- R6: While `rx_busy_i` is 1, `rx_allow_o` holds its value, so a character being received completes before reception stops.
- R7: With CTS flow control on (bit 15), `tx_allow_o` can rise only while the synchronized `cts_ni` is low. A change on `cts_ni` reaches `tx_allow_o` three clocks later. A CTS deassertion during a character does not drop `tx_allow_o`.
- R8: With automatic RTS on (bit 14), `rts_no` is the inverse of `rx_fifo_room_i`, registered one clock, and bit 11 is ignored.
- R9: With automatic RTS off, `rts_no` is the inverse of bit 11, registered one clock.
- R10: Bits 7, 2 and 1 are stored but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Register read value |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| rx_fifo_room_i | input | 1 | Receive FIFO can take another character |
| tx_busy_i | input | 1 | Transmitter is mid-character |
| rx_busy_i | input | 1 | Receiver is mid-character |
| tx_allow_o | output | 1 | Transmitter may start a character |
| rx_allow_o | output | 1 | Receiver may accept a character |
| rts_no | output | 1 | Request-to-send pin, active low |

## Verification
Random register writes over all 32 bits are mixed with random busy runs, slowly toggling CTS and random FIFO space. Every output is compared each cycle against a cycle-accurate reference model. This separates correct enable combinations and one-cycle latency from wrong masks or wrong bit positions. Directed sequences then target the cases that random runs seldom reach:
- disabling a section mid-character, which separates holding from cutting the character off;
- CTS dropping after a character starts, versus CTS being high at a boundary;
- software RTS written while automatic RTS is on, which shows whether the bit is ignored;
- the unused stored bits toggled while the enables stay unchanged.

// File: rtl/uart_ctrl_pkg.sv
package uart_ctrl_pkg;
  localparam int unsigned CR_W = 16;
  localparam logic [CR_W-1:0] CR_RESET = 16'h0300;
  localparam logic [CR_W-1:0] CR_MASK  = 16'hCF87;
  localparam int unsigned B_UEN   = 0;
  localparam int unsigned B_TXE   = 8;
  localparam int unsigned B_RXE   = 9;
  localparam int unsigned B_SWRTS = 11;
  localparam int unsigned B_RTSFC = 14;
  localparam int unsigned B_CTSFC = 15;
endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CR_W-1:0]   ctrl_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [CR_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CR_RESET;
    else if (wr_en_i) ctrl_q <= wr_data_i[CR_W-1:0] & CR_MASK;
  end

  assign ctrl_o    = ctrl_q;
  assign rd_data_o = {{(DATA_W-CR_W){1'b0}}, ctrl_q};

  assert_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_o == ($past(wr_data_i[CR_W-1:0]) & CR_MASK));
endmodule

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_no
);
  logic [STAGES-1:0] pipe_q;

  // resets to deasserted (high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], async_ni};
  end

  assign sync_no = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_char_gate.sv
module uart_char_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic busy_i,
  output logic allow_o
);
  logic allow_q;

  // decision is only re-taken at a character boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      allow_q <= 1'b0;
    else if (!busy_i) allow_q <= want_i;
  end

  assign allow_o = allow_q;

  assert_hold_busy_R5_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(allow_o));
endmodule

// File: rtl/uart_rts_drive.sv
module uart_rts_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic fifo_room_i,
  input  logic sw_rts_i,
  output logic rts_no
);
  logic rts_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rts_nq <= 1'b1;
    else if (auto_en_i) rts_nq <= ~fifo_room_i;
    else                rts_nq <= ~sw_rts_i;
  end

  assign rts_no = rts_nq;
endmodule

// File: rtl/uart_ctrl_unit.sv
module uart_ctrl_unit
  import uart_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CTS_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cts_ni,
  input  logic              rx_fifo_room_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  output logic              tx_allow_o,
  output logic              rx_allow_o,
  output logic              rts_no
);
  logic [CR_W-1:0] ctrl;
  logic            cts_sync_n;
  logic            cts_ok;
  logic            tx_want;
  logic            rx_want;

  uart_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .ctrl_o(ctrl), .rd_data_o
  );

  uart_cts_sync #(.STAGES(CTS_STAGES)) u_cts (
    .clk_i, .rst_ni, .async_ni(cts_ni), .sync_no(cts_sync_n)
  );

  assign cts_ok  = ~ctrl[B_CTSFC] | ~cts_sync_n;
  assign tx_want = ctrl[B_UEN] & ctrl[B_TXE] & cts_ok;
  assign rx_want = ctrl[B_UEN] & ctrl[B_RXE];

  uart_char_gate u_tx_gate (
    .clk_i, .rst_ni, .want_i(tx_want), .busy_i(tx_busy_i), .allow_o(tx_allow_o)
  );

  uart_char_gate u_rx_gate (
    .clk_i, .rst_ni, .want_i(rx_want), .busy_i(rx_busy_i), .allow_o(rx_allow_o)
  );

  uart_rts_drive u_rts (
    .clk_i, .rst_ni, .auto_en_i(ctrl[B_RTSFC]), .fifo_room_i(rx_fifo_room_i),
    .sw_rts_i(ctrl[B_SWRTS]), .rts_no
  );

  assert_tx_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_allow_o) |-> $past(ctrl[B_UEN] && ctrl[B_TXE]));

  assert_rx_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_allow_o) |-> $past(ctrl[B_UEN] && ctrl[B_RXE]));

  assert_cts_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_allow_o) && $past(ctrl[B_CTSFC])) |-> $past(!cts_sync_n));

  assert_rts_auto_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl[B_RTSFC]) |-> (rts_no == !$past(rx_fifo_room_i)));

  assert_rts_sw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl[B_RTSFC]) |-> (rts_no == !$past(ctrl[B_SWRTS])));
endmodule

// File: tb/uart_ctrl_unit_tb.sv
module uart_ctrl_unit_tb;
  localparam int DATA_W = 32;
  localparam logic [15:0] MASK = 16'hCF87;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic cts_n = 1'b1, room = 1'b0, tx_busy = 1'b0, rx_busy = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic tx_allow, rx_allow, rts_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_ctrl_unit #(.DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .cts_ni(cts_n), .rx_fifo_room_i(room),
    .tx_busy_i(tx_busy), .rx_busy_i(rx_busy), .tx_allow_o(tx_allow),
    .rx_allow_o(rx_allow), .rts_no(rts_n)
  );

  // reference model, built from the requirements
  logic [15:0] m_reg;
  logic m_c1, m_c2, m_tx, m_rx, m_rts;

  function automatic logic f_tx_want(logic [15:0] r, logic c2);
    return r[0] & r[8] & (~r[15] | ~c2);
  endfunction
  function automatic logic f_rx_want(logic [15:0] r);
    return r[0] & r[9];
  endfunction
  function automatic logic f_rts(logic [15:0] r, logic rm);
    return r[14] ? ~rm : ~r[11];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 16'h0300; m_c1 <= 1'b1; m_c2 <= 1'b1;
      m_tx <= 1'b0; m_rx <= 1'b0; m_rts <= 1'b1;
    end else begin
      if (!tx_busy) m_tx <= f_tx_want(m_reg, m_c2);
      if (!rx_busy) m_rx <= f_rx_want(m_reg);
      m_rts <= f_rts(m_reg, room);
      m_c1  <= cts_n;
      m_c2  <= m_c1;
      if (wr_en) m_reg <= wr_data[15:0] & MASK;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: compare at negedge, then drive
  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 readback", rd_data, {16'h0, m_reg});
      chk("R3 R5 R7 R10 tx_allow", 32'(tx_allow), 32'(m_tx));
      chk("R4 R6 R10 rx_allow", 32'(rx_allow), 32'(m_rx));
      chk("R8 R9 rts", 32'(rts_n), 32'(m_rts));
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset reg", rd_data, 32'h0300);
    chk("R1 reset tx", 32'(tx_allow), 0);
    chk("R1 reset rx", 32'(rx_allow), 0);
    chk("R1 reset rts", 32'(rts_n), 1);

    // R2: reserved bits clear, bit10 kept
    wr(32'hFFFF_FFFF); cyc(1);
    chk("R2 mask", rd_data, 32'h0000_CF87);
    wr(32'h0000_0000); cyc(1);
    chk("R2 clear", rd_data, 32'h0);

    // R3 / R10: stored-only bits do not enable anything
    wr(32'h0000_0386); cyc(2);
    chk("R10 no enable", 32'(tx_allow), 0);
    wr(32'h0000_0301); cyc(1);
    chk("R3 tx on", 32'(tx_allow), 1);
    chk("R4 rx on", 32'(rx_allow), 1);
    wr(32'h0000_0387); cyc(1);
    chk("R10 tx unchanged", 32'(tx_allow), 1);
    chk("R10 rts unchanged", 32'(rts_n), 1);

    // R5 / R6: disable mid-character
    tx_busy = 1'b1; rx_busy = 1'b1;
    wr(32'h0000_0000); cyc(4);
    chk("R5 tx held", 32'(tx_allow), 1);
    chk("R6 rx held", 32'(rx_allow), 1);
    tx_busy = 1'b0; rx_busy = 1'b0;
    cyc(1);
    chk("R5 tx stop", 32'(tx_allow), 0);
    chk("R6 rx stop", 32'(rx_allow), 0);

    // R7: CTS gating with 3-cycle path
    cts_n = 1'b1;
    wr(32'h0000_8301); cyc(4);
    chk("R7 blocked", 32'(tx_allow), 0);
    cts_n = 1'b0;
    cyc(2);
    chk("R7 not yet", 32'(tx_allow), 0);
    cyc(1);
    chk("R7 start", 32'(tx_allow), 1);
    tx_busy = 1'b1; cts_n = 1'b1;
    cyc(5);
    chk("R7 no cutoff", 32'(tx_allow), 1);
    tx_busy = 1'b0;
    cyc(1);
    chk("R7 boundary stop", 32'(tx_allow), 0);

    // R9 / R8
    wr(32'h0000_0800); cyc(1);
    chk("R9 sw rts low", 32'(rts_n), 0);
    wr(32'h0000_0000); cyc(1);
    chk("R9 sw rts high", 32'(rts_n), 1);
    room = 1'b0;
    wr(32'h0000_4800); cyc(1);
    chk("R8 sw ignored", 32'(rts_n), 1);
    room = 1'b1; cyc(1);
    chk("R8 room", 32'(rts_n), 0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(7) == 0) begin
        wr_en = 1'b1;
        wr_data = $urandom();
        if ($urandom_range(1)) wr_data[0] = 1'b1;
      end
      if ($urandom_range(5) == 0) tx_busy = ~tx_busy;
      if ($urandom_range(5) == 0) rx_busy = ~rx_busy;
      if ($urandom_range(9) == 0) cts_n = ~cts_n;
      if ($urandom_range(3) == 0) room = $urandom_range(1);
      cyc(1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule